// File: doc/BRIEF.md
# Touch ADC Scan Sequencer

This block is a serial-interface master that runs a complete scan of a resistive-touch converter. A start pulse latches an 8-bit channel-enable mask. The sequencer then visits each enabled channel from the lowest index to the highest. For every channel it sends a burst of 24-bit sample frames. It throws away a programmable number of leading settling frames. It averages the remaining samples with upward rounding and writes one 12-bit result per channel into a result bank. When the last channel has been written, it pulses a done flag.

Each channel has two per-channel settings: a settle-frame count and an oversampling ratio. Host logic sets them through a simple write port while the sequencer is idle. The reset value of the settle count is derived from a settling time parameter. The time is converted to serial bit periods, rounded up, and then to whole 24-bit frames, also rounded up. The serial link uses clock mode 0. Chip select is held low across the whole scan.

Top module: `touch_scan_seq`

## Requirements
- R1: Enabled channels are visited strictly in ascending index order, and no frame is sent for a disabled channel. The result of a disabled channel keeps its previous value, and the results never change while the block is idle.
- R2: The command byte of every frame is laid out as follows. Bit 7 is 1. Bits 6:4 hold the channel index. Bit 3 is 0, which selects 12-bit conversion. Bits 2 and 1 are both 1 for channels 0, 2, 6 and 7, and both 0 for channels 1, 3, 4 and 5.
- R3: Bit 0 of the command byte (converter keep-on) is 1 on every frame of a burst except the last, where it is 0.
- R4: A channel's burst has exactly settle + ratio frames, where the ratio equals the programmed ratio field plus 1 (range 1 to 256). The first settle frames are excluded from the average.
- R5: Each frame returns a 16-bit word in its second and third bytes, most significant bit first. The sample is word bits 14:3. The result is ceil(sum of kept samples / ratio), which stays exact up to 256 samples of 4095.
- R6: The serial clock idles low whenever chip select is high. Data leaves MSB first and does not change while the clock is high. The input is captured on the rising edge. One clock period lasts 2*SCLK_HALF system clocks.
- R7: Chip select goes low once at the start of a non-empty scan and stays low through every frame of every enabled channel. It rises once, after the final frame of the last channel.
- R8: A start pulse while busy is ignored. The running scan keeps its mask, and only one done pulse results.
- R9: A start with an all-zero mask raises done in the next cycle, with no serial activity and busy staying low.
- R10: Done is a one-cycle pulse raised in the cycle that the last result is written. Busy falls in the same cycle.
- R11: After reset, busy and done are low, chip select is high, the clock is low and all results are 0. Every channel has ratio 1 and a settle count of ceil(ceil(SETTLE_NS / bit period) / 24) frames.
- R12: Configuration writes are ignored while busy. A write in the same cycle as an accepted start is applied and governs the scan it starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Scan request pulse |
| chan_mask | input | 8 | Channel-enable mask latched at start |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ch | input | 3 | Channel selected by the write |
| cfg_settle | input | SETTLE_W | Settle-frame count to store |
| cfg_ovs | input | OVS_W | Oversampling ratio minus one |
| busy | output | 1 | Scan in progress |
| scan_done | output | 1 | One-cycle completion pulse |
| results | output | 96 | Result bank, channel n at bits 12n+11:12n |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the converter |
| spi_miso | input | 1 | Serial data from the converter |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The configuration port and the scan start can act in the same cycle. A write that lands on the accepting start edge must shape that scan's bursts, while a write one cycle later must be dropped. The bench drives both strobes on one edge and then judges the result by counting the frames the converter model receives for the targeted channel. A second coincidence is a start pulse arriving mid-scan. It is judged by the channel sequence in the command bytes and by counting the done pulses.

// File: rtl/tsq_pkg.sv
package tsq_pkg;

  localparam int TSQ_NCH        = 8;
  localparam int TSQ_RES_W      = 12;
  localparam int TSQ_FRAME_BITS = 24;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PICK,
    ST_GO,
    ST_WAIT,
    ST_DIVGO,
    ST_DIV
  } tsq_state_e;

  // Command byte: start, address, 12-bit mode, reference select pair, keep-on.
  function automatic logic [7:0] tsq_cmd(input logic [2:0] ch, input logic last);
    logic single;
    single = (ch == 3'd0) || (ch == 3'd2) || (ch == 3'd6) || (ch == 3'd7);
    return {1'b1, ch, 1'b0, single, single, ~last};
  endfunction

  // 12-bit sample sits in bits 14:3 of the returned word.
  function automatic logic [TSQ_RES_W-1:0] tsq_sample(input logic [15:0] w);
    return w[14:3];
  endfunction

  // Index of the lowest set bit (0 when none is set).
  function automatic logic [2:0] tsq_first(input logic [TSQ_NCH-1:0] m);
    logic [2:0] f;
    f = 3'd0;
    for (int i = TSQ_NCH - 1; i >= 0; i--) begin
      if (m[i]) f = 3'(i);
    end
    return f;
  endfunction

endpackage

// File: rtl/tsq_spi_frame.sv
module tsq_spi_frame #(
  parameter int HALF       = 34,
  parameter int FRAME_BITS = 24
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        go,
  input  logic [7:0]  cmd,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic        frame_done,
  output logic [15:0] rx_word
);
  localparam int PH_N  = 2 * HALF;
  localparam int PH_W  = (PH_N > 2) ? $clog2(PH_N) : 1;
  localparam int BIT_W = $clog2(FRAME_BITS);

  logic                  active;
  logic [PH_W-1:0]       ph;
  logic [BIT_W-1:0]      bcnt;
  logic [FRAME_BITS-1:0] tx;
  logic [15:0]           rx;
  logic                  sclk_q;
  logic                  done_q;

  wire rise_now = active && (ph == PH_W'(HALF - 1));
  wire fall_now = active && (ph == PH_W'(PH_N - 1));
  wire last_bit = (bcnt == BIT_W'(FRAME_BITS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      ph     <= '0;
      bcnt   <= '0;
      tx     <= '0;
      rx     <= '0;
      sclk_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (go && !active) begin
        active <= 1'b1;
        ph     <= '0;
        bcnt   <= '0;
        tx     <= {cmd, {(FRAME_BITS-8){1'b0}}};
        sclk_q <= 1'b0;
      end else if (active) begin
        if (rise_now) begin
          sclk_q <= 1'b1;
          rx     <= {rx[14:0], miso};
        end
        if (fall_now) begin
          sclk_q <= 1'b0;
          ph     <= '0;
          if (last_bit) begin
            active <= 1'b0;
            done_q <= 1'b1;
          end else begin
            bcnt <= bcnt + BIT_W'(1);
            tx   <= {tx[FRAME_BITS-2:0], 1'b0};
          end
        end else begin
          ph <= ph + PH_W'(1);
        end
      end
    end
  end

  assign sclk       = sclk_q;
  assign mosi       = active ? tx[FRAME_BITS-1] : 1'b0;
  assign frame_done = done_q;
  assign rx_word    = rx;
endmodule

// File: rtl/tsq_divider.sv
module tsq_divider #(
  parameter int NUM_W = 20,
  parameter int DEN_W = 9,
  parameter int QUO_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic [NUM_W-1:0] num,
  input  logic [DEN_W-1:0] den,
  output logic [QUO_W-1:0] quo,
  output logic             valid
);
  localparam int CNT_W = $clog2(NUM_W + 1);

  logic             run;
  logic [CNT_W-1:0] cnt;
  logic [NUM_W-1:0] q;
  logic [DEN_W-1:0] rem;
  logic [DEN_W-1:0] den_q;
  logic             valid_q;

  wire [DEN_W:0] trial = {rem, q[NUM_W-1]};
  wire           fits  = trial >= {1'b0, den_q};
  wire [DEN_W:0] diff  = trial - {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      cnt     <= '0;
      q       <= '0;
      rem     <= '0;
      den_q   <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (go) begin
        q     <= num;
        rem   <= '0;
        den_q <= den;
        cnt   <= CNT_W'(NUM_W);
        run   <= 1'b1;
      end else if (run) begin
        rem <= fits ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
        q   <= {q[NUM_W-2:0], fits};
        cnt <= cnt - CNT_W'(1);
        if (cnt == CNT_W'(1)) begin
          run     <= 1'b0;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign quo   = q[QUO_W-1:0];
  assign valid = valid_q;
endmodule

// File: rtl/touch_scan_seq.sv
module touch_scan_seq
  import tsq_pkg::*;
#(
  parameter int SETTLE_W      = 4,
  parameter int OVS_W         = 8,
  parameter int SCLK_HALF     = 34,
  parameter int CLK_PERIOD_NS = 5,
  parameter int SETTLE_NS     = 1000
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start,
  input  logic [7:0]                   chan_mask,
  input  logic                         cfg_we,
  input  logic [2:0]                   cfg_ch,
  input  logic [SETTLE_W-1:0]          cfg_settle,
  input  logic [OVS_W-1:0]             cfg_ovs,
  output logic                         busy,
  output logic                         scan_done,
  output logic [TSQ_NCH*TSQ_RES_W-1:0] results,
  output logic                         spi_sclk,
  output logic                         spi_mosi,
  input  logic                         spi_miso,
  output logic                         spi_cs_n
);
  localparam int NCH        = TSQ_NCH;
  localparam int RES_W      = TSQ_RES_W;
  localparam int ACC_W      = RES_W + OVS_W;
  localparam int DEN_W      = OVS_W + 1;
  localparam int LEN_W      = ((SETTLE_W > DEN_W) ? SETTLE_W : DEN_W) + 1;
  localparam int BIT_NS     = CLK_PERIOD_NS * 2 * SCLK_HALF;
  localparam int SET_BITS   = (SETTLE_NS + BIT_NS - 1) / BIT_NS;
  localparam int SET_FR     = (SET_BITS + TSQ_FRAME_BITS - 1) / TSQ_FRAME_BITS;
  localparam int SET_MAX    = (1 << SETTLE_W) - 1;
  localparam int DEF_SETTLE = (SET_FR > SET_MAX) ? SET_MAX : SET_FR;

  tsq_state_e         state;
  logic [NCH-1:0]     pend;
  logic [2:0]         cur_ch;
  logic [LEN_W-1:0]   fidx;
  logic [ACC_W-1:0]   acc;
  logic               cs_n_q;
  logic               done_q;

  logic [SETTLE_W-1:0] settle_r [NCH];
  logic [OVS_W-1:0]    ovs_r    [NCH];
  logic [RES_W-1:0]    res_r    [NCH];

  // Named internal events.
  logic               frame_end;
  logic               burst_last;
  logic               div_done;
  logic [15:0]        rx_word;
  logic [RES_W-1:0]   div_quo;

  wire                accept_start = start && (state == ST_IDLE);
  wire                cfg_apply    = cfg_we && (state == ST_IDLE);
  wire [SETTLE_W-1:0] cur_settle   = settle_r[cur_ch];
  wire [DEN_W-1:0]    cur_den      = DEN_W'(ovs_r[cur_ch]) + DEN_W'(1);
  wire [LEN_W-1:0]    burst_len    = LEN_W'(cur_settle) + LEN_W'(cur_den);
  wire                keep_frame   = fidx >= LEN_W'(cur_settle);
  wire [RES_W-1:0]    sample       = tsq_sample(rx_word);
  wire [NCH-1:0]      pend_clr     = pend & ~(NCH'(1) << cur_ch);
  wire [ACC_W-1:0]    div_num      = acc + ACC_W'(cur_den) - ACC_W'(1);
  wire                frame_go     = (state == ST_GO);
  wire                div_go       = (state == ST_DIVGO);

  assign burst_last = (fidx == burst_len - LEN_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= ST_IDLE;
      pend   <= '0;
      cur_ch <= '0;
      fidx   <= '0;
      acc    <= '0;
      cs_n_q <= 1'b1;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept_start) begin
            if (chan_mask == '0) begin
              done_q <= 1'b1;
            end else begin
              pend  <= chan_mask;
              state <= ST_PICK;
            end
          end
        end
        ST_PICK: begin
          cur_ch <= tsq_first(pend);
          fidx   <= '0;
          acc    <= '0;
          cs_n_q <= 1'b0;
          state  <= ST_GO;
        end
        ST_GO: state <= ST_WAIT;
        ST_WAIT: begin
          if (frame_end) begin
            if (keep_frame) acc <= acc + ACC_W'(sample);
            if (burst_last) begin
              pend <= pend_clr;
              if (pend_clr == '0) cs_n_q <= 1'b1;
              state <= ST_DIVGO;
            end else begin
              fidx  <= fidx + LEN_W'(1);
              state <= ST_GO;
            end
          end
        end
        ST_DIVGO: state <= ST_DIV;
        ST_DIV: begin
          if (div_done) begin
            if (pend == '0) begin
              done_q <= 1'b1;
              state  <= ST_IDLE;
            end else begin
              state <= ST_PICK;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  generate
    for (genvar g = 0; g < NCH; g++) begin : g_chan
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          settle_r[g] <= SETTLE_W'(DEF_SETTLE);
          ovs_r[g]    <= '0;
          res_r[g]    <= '0;
        end else begin
          if (cfg_apply && (cfg_ch == 3'(g))) begin
            settle_r[g] <= cfg_settle;
            ovs_r[g]    <= cfg_ovs;
          end
          if (div_done && (state == ST_DIV) && (cur_ch == 3'(g))) begin
            res_r[g] <= div_quo;
          end
        end
      end
      assign results[g*RES_W +: RES_W] = res_r[g];
    end
  endgenerate

  tsq_spi_frame #(
    .HALF       (SCLK_HALF),
    .FRAME_BITS (TSQ_FRAME_BITS)
  ) u_frame (
    .clk        (clk),
    .rst_n      (rst_n),
    .go         (frame_go),
    .cmd        (tsq_cmd(cur_ch, burst_last)),
    .miso       (spi_miso),
    .sclk       (spi_sclk),
    .mosi       (spi_mosi),
    .frame_done (frame_end),
    .rx_word    (rx_word)
  );

  tsq_divider #(
    .NUM_W (ACC_W),
    .DEN_W (DEN_W),
    .QUO_W (RES_W)
  ) u_div (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (div_go),
    .num   (div_num),
    .den   (cur_den),
    .quo   (div_quo),
    .valid (div_done)
  );

  assign busy      = (state != ST_IDLE);
  assign scan_done = done_q;
  assign spi_cs_n  = cs_n_q;
endmodule

// File: rtl/tsq_checker.sv
module tsq_checker #(
  parameter int RES_BITS = 96
) (
  input logic                clk,
  input logic                rst_n,
  input logic                start,
  input logic [7:0]          chan_mask,
  input logic                busy,
  input logic                scan_done,
  input logic [RES_BITS-1:0] results,
  input logic                spi_sclk,
  input logic                spi_cs_n,
  input logic                frame_end,
  input logic                burst_last
);
  // R6: clock idles low while deselected.
  p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sclk);

  // R7: select held low between frames of a scan.
  p_cs_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && !burst_last) |=> !spi_cs_n);

  // R9: empty mask completes at once with no selection.
  p_zero_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && (chan_mask == 8'd0)) |=> (scan_done && spi_cs_n && !busy));

  // R10: busy only falls together with done.
  p_busy_fall_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> scan_done);

  // R10: done never overlaps a running scan.
  p_done_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    scan_done |-> !busy);

  // R1: results frozen while idle.
  p_results_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(results));
endmodule

bind touch_scan_seq tsq_checker #(
  .RES_BITS (tsq_pkg::TSQ_NCH * tsq_pkg::TSQ_RES_W)
) u_tsq_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .chan_mask  (chan_mask),
  .busy       (busy),
  .scan_done  (scan_done),
  .results    (results),
  .spi_sclk   (spi_sclk),
  .spi_cs_n   (spi_cs_n),
  .frame_end  (frame_end),
  .burst_last (burst_last)
);

// File: tb/touch_scan_seq_bench.sv
`timescale 1ns/1ps
module touch_scan_seq_bench;
  localparam int H   = 2;
  localparam int CP  = 5;
  localparam int SNS = 1000;
  localparam int SW  = 4;
  localparam int OW  = 8;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           start = 1'b0;
  logic [7:0]     chan_mask = '0;
  logic           cfg_we = 1'b0;
  logic [2:0]     cfg_ch = '0;
  logic [SW-1:0]  cfg_settle = '0;
  logic [OW-1:0]  cfg_ovs = '0;
  logic           busy, scan_done, spi_sclk, spi_mosi, spi_cs_n;
  logic           spi_miso = 1'b0;
  logic [95:0]    results;

  touch_scan_seq #(
    .SETTLE_W(SW), .OVS_W(OW), .SCLK_HALF(H), .CLK_PERIOD_NS(CP), .SETTLE_NS(SNS)
  ) u_touch_scan_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .chan_mask(chan_mask),
    .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_settle(cfg_settle), .cfg_ovs(cfg_ovs),
    .busy(busy), .scan_done(scan_done), .results(results),
    .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
  );

  always #2.5 clk = ~clk;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  int  q_cmd[$];
  int  q_smp[$];
  int  idx = 0;
  int  gcnt = 0;
  int  cur_smp = 0;
  int  cmd_sh = 0;
  bit  force_max = 0;
  real last_rise = 0.0;
  logic mosi_at_rise = 1'b0;

  always @(posedge spi_sclk) begin
    mosi_at_rise = spi_mosi;
    if (!spi_cs_n) begin
      if (idx != 0)
        check(($realtime - last_rise) == real'(2*H*CP), "R6 sclk period",
              longint'($realtime - last_rise), 2*H*CP);
      last_rise = $realtime;
      if (idx == 0) begin
        cur_smp = force_max ? 4095 : ((gcnt * 733 + 129) % 4096);
        cmd_sh = 0;
      end
      if (idx < 8) cmd_sh = ((cmd_sh << 1) | int'(spi_mosi)) & 255;
      idx++;
      if (idx == 24) begin
        q_cmd.push_back(cmd_sh);
        q_smp.push_back(cur_smp);
        idx = 0;
        gcnt++;
      end
    end
  end

  always @(negedge spi_sclk) begin
    if (idx >= 9 && idx <= 20) spi_miso = 1'(cur_smp >> (20 - idx));
    else spi_miso = 1'b0;
  end

  // ---------------- per-clock observation ----------------
  int cs_rise = 0, cs_fall = 0, done_cnt = 0;
  always @(posedge spi_cs_n) if (rst_n) cs_rise++;
  always @(negedge spi_cs_n) if (rst_n) cs_fall++;

  always @(negedge clk) begin
    if (rst_n) begin
      if (scan_done) done_cnt++;
      check(!(spi_cs_n && spi_sclk), "R6 clock idle while deselected", spi_sclk, 0);
      if (spi_sclk)
        check(spi_mosi == mosi_at_rise, "R6 data stable while clock high", spi_mosi, mosi_at_rise);
      if (scan_done) check(!busy, "R10 busy low with done", busy, 0);
    end
  end

  // ---------------- bench-side model ----------------
  int b_settle[8];
  int b_ratio[8];
  int exp_res[8];

  function automatic int exp_cmd(input int ch, input bit last);
    int v;
    v = 128 + ch * 16;
    if (ch == 0 || ch == 2 || ch >= 6) v += 6;
    if (!last) v += 1;
    return v;
  endfunction

  task automatic cfg_write(input int ch, input int st, input int ratio, input bit shadow);
    @(negedge clk);
    cfg_we = 1; cfg_ch = 3'(ch); cfg_settle = SW'(st); cfg_ovs = OW'(ratio - 1);
    @(negedge clk);
    cfg_we = 0;
    if (shadow) begin b_settle[ch] = st; b_ratio[ch] = ratio; end
  endtask

  task automatic wait_done();
    int n;
    n = 0;
    while (!scan_done && n < 60000) begin @(negedge clk); n++; end
    check(scan_done, "R10 done reached", scan_done, 1);
  endtask

  task automatic check_scan(input logic [7:0] m, input string tag);
    int total;
    total = 0;
    for (int c = 0; c < 8; c++) if (m[c]) total += b_settle[c] + b_ratio[c];
    check(q_cmd.size() == total, {"R4 frame count ", tag}, q_cmd.size(), total);
    for (int c = 0; c < 8; c++) begin
      if (m[c]) begin
        int len, sum, cmd, smp;
        len = b_settle[c] + b_ratio[c];
        sum = 0;
        for (int k = 0; k < len; k++) begin
          if (q_cmd.size() == 0) begin
            check(0, "R4 missing frame", k, len);
            break;
          end
          cmd = q_cmd.pop_front();
          smp = q_smp.pop_front();
          check((cmd >> 1) == (exp_cmd(c, k == len - 1) >> 1), "R2 R1 command byte", cmd, exp_cmd(c, k == len - 1));
          check((cmd & 1) == (exp_cmd(c, k == len - 1) & 1), "R3 keep-on bit", cmd & 1, exp_cmd(c, k == len - 1) & 1);
          if (k >= b_settle[c]) sum += smp;
        end
        exp_res[c] = (sum + b_ratio[c] - 1) / b_ratio[c];
        check(results[c*12 +: 12] == 12'(exp_res[c]), "R5 averaged result", results[c*12 +: 12], exp_res[c]);
      end else begin
        check(results[c*12 +: 12] == 12'(exp_res[c]), "R1 disabled channel kept", results[c*12 +: 12], exp_res[c]);
      end
    end
    q_cmd.delete();
    q_smp.delete();
  endtask

  task automatic do_scan(input logic [7:0] m, input string tag);
    cs_rise = 0; cs_fall = 0; done_cnt = 0;
    @(negedge clk);
    start = 1; chan_mask = m;
    @(negedge clk);
    start = 0;
    wait_done();
    @(negedge clk);
    check_scan(m, tag);
    check(cs_fall == 1 && cs_rise == 1, "R7 single select window", cs_fall * 10 + cs_rise, 11);
    check(done_cnt == 1, "R10 single done pulse", done_cnt, 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      check(0, "watchdog expired", 0, 1);
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    int def_settle;
    def_settle = (((SNS + 2*H*CP - 1) / (2*H*CP)) + 23) / 24;
    for (int c = 0; c < 8; c++) begin b_settle[c] = def_settle; b_ratio[c] = 1; exp_res[c] = 0; end

    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !scan_done, "R11 reset idle", busy, 0);
    check(spi_cs_n && !spi_sclk, "R11 reset serial lines", {spi_cs_n, spi_sclk}, 2);
    check(results == '0, "R11 reset results", results[11:0], 0);

    // R11: default burst length from the settling time
    do_scan(8'hA5, "R11 defaults");

    // mixed configuration, R4 and R5
    cfg_write(1, 0, 4, 1);
    cfg_write(3, 2, 3, 1);
    cfg_write(7, 1, 5, 1);
    cfg_write(4, 0, 1, 1);
    do_scan(8'h9A, "mixed");

    // R9: empty mask
    cs_fall = 0;
    @(negedge clk);
    start = 1; chan_mask = 8'h00;
    @(negedge clk);
    check(scan_done, "R9 done next cycle", scan_done, 1);
    check(!busy, "R9 busy stays low", busy, 0);
    start = 0;
    repeat (5) @(negedge clk);
    check(cs_fall == 0 && q_cmd.size() == 0, "R9 no serial activity", cs_fall + q_cmd.size(), 0);

    // R8: start during a scan is ignored
    cs_rise = 0; cs_fall = 0; done_cnt = 0;
    @(negedge clk);
    start = 1; chan_mask = 8'h01;
    @(negedge clk);
    start = 0;
    repeat (20) @(negedge clk);
    start = 1; chan_mask = 8'hFF;
    @(negedge clk);
    start = 0;
    wait_done();
    @(negedge clk);
    check_scan(8'h01, "R8 ignored start");
    check(done_cnt == 1, "R8 one done pulse", done_cnt, 1);

    // R12: write while busy is dropped
    @(negedge clk);
    start = 1; chan_mask = 8'h02;
    @(negedge clk);
    start = 0;
    repeat (3) @(negedge clk);
    cfg_write(1, 5, 7, 0);
    wait_done();
    @(negedge clk);
    check_scan(8'h02, "R12 busy write");
    do_scan(8'h02, "R12 old config kept");

    // R12: write on the accepting start edge governs that scan
    @(negedge clk);
    start = 1; chan_mask = 8'h02;
    cfg_we = 1; cfg_ch = 3'd1; cfg_settle = SW'(2); cfg_ovs = OW'(2);
    @(negedge clk);
    start = 0; cfg_we = 0;
    b_settle[1] = 2; b_ratio[1] = 3;
    wait_done();
    @(negedge clk);
    check_scan(8'h02, "R12 same-cycle write");

    // R5: full-scale accumulation with 256 samples
    force_max = 1;
    cfg_write(6, 0, 256, 1);
    do_scan(8'h40, "R5 full scale");
    check(results[6*12 +: 12] == 12'hFFF, "R5 full-scale result", results[6*12 +: 12], 4095);
    force_max = 0;

    // all channels
    cfg_write(0, 1, 2, 1);
    cfg_write(2, 0, 3, 1);
    cfg_write(5, 3, 2, 1);
    cfg_write(6, 1, 4, 1);
    do_scan(8'hFF, "R1 all channels");

    finished = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule